// File: doc/BRIEF.md
# Serial Bit-Time Measurement Counter

This block times pulses on an asynchronous serial receive line so that surrounding logic can recover an unknown baud rate or measure a received break. A single counter is shared by two measurement styles. The first times the interval between two successive falling edges of the line. The second times how long the line stays low. Counting is driven by single-cycle enable strobes derived inside one clock domain. One strobe comes from the bus clock divided by four. The other is the external serial prescaler strobe divided by two.

A control write selects the behaviour and, whatever value it carries, clears the count and all status. Mode code 2'b01 arms a measurement. Any other code parks the block idle with a zero count. The clock-select bit picks the style: 0 for edge-to-edge, 1 for low duration. The result is presented as an upper part and a low byte. Running, finished and a sticky overflow flag report progress. Once a measurement finishes, its value is frozen until the next control write.

Top module: `bittime_meter`

## Requirements
- R1: After reset the count reads zero and running, finished and overflow are all low. The count is CNT_W bits wide, read as `cnt_hi` (upper CNT_W-8 bits) and `cnt_lo` (low 8 bits).
- R2: When armed with clock select 0, counting starts on a falling edge of the synchronised line and stops on the next falling edge. If the two edges are P clock cycles apart, the frozen count is floor((P-1)/4). When not running, the count changes only on a control write.
- R3: `running` is high exactly while counting. `finished` rises when the stop event ends the measurement. The two are never high together.
- R4: When armed with clock select 1, counting starts when the synchronised line is low and stops on its next rising edge. With `ser_clk_en` held high and a low pulse lasting L cycles, the frozen count is floor((L-1)/2).
- R5: Arming with clock select 1 while the line is already low starts counting without any edge.
- R6: An increment from the all-ones count wraps to zero and sets `overflow`, which stays set until a control write or reset.
- R7: Every control write clears the count, `overflow` and `finished`, whatever mode it carries.
- R8: A control write with a mode code other than 2'b01 (00, 10 or 11) leaves the block idle. Line edges then neither start counting nor change the zero count.
- R9: After `finished` is set, the count and `finished` hold through further line activity until the next control write.
- R10: With clock select 1, the count advances only on `ser_clk_en` strobes. With the strobe held low, a measurement ends with a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Asynchronous serial receive line, idle high |
| ser_clk_en | input | 1 | One-cycle strobe from the serial prescaler |
| ctl_wr | input | 1 | Control write strobe |
| ctl_mode | input | 2 | Mode code: 01 measure, others idle |
| ctl_clksel | input | 1 | 0 edge-to-edge at bus/4, 1 low duration at serial/2 |
| cnt_hi | output | CNT_W-8 | Upper bits of the count |
| cnt_lo | output | 8 | Low byte of the count |
| running | output | 1 | Counter is counting |
| finished | output | 1 | Measurement complete, value frozen |
| overflow | output | 1 | Sticky counter-wrap flag |

## Verification
The bench builds the block with its defaults: a 9-bit counter, a bus divider of 4, a serial divider of 2 and a two-stage synchroniser. At these values a low pulse of about a thousand cycles, timed against a continuous serial strobe, drives the counter past 511. This makes the wrap and the sticky overflow reachable in a short run. It also keeps the expected counts small integers the scoreboard computes from pulse lengths alone.

// File: rtl/bt_pkg.sv
package bt_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ARMED = 2'd1,
      PH_RUN   = 2'd2,
      PH_DONE  = 2'd3
   } bt_phase_t;

   localparam logic [1:0] BT_MODE_MEASURE = 2'b01;

endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              lvl_q;

   // line idles high, so reset every stage to 1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         lvl_q <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], d_async};
         lvl_q <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/bt_rate.sv
module bt_rate #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic src_en,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = src_en & ~clr;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] phase_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_cnt <= '0;
            end else if (clr) begin
               phase_cnt <= '0;
            end else if (src_en) begin
               phase_cnt <= (phase_cnt == LAST) ? '0 : phase_cnt + 1'b1;
            end
         end

         assign tick = ~clr & src_en & (phase_cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/bt_core.sv
module bt_core
   import bt_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       mode,
   input  logic             clksel,
   input  logic             lvl,
   input  logic             rise,
   input  logic             fall,
   input  logic             tick_bus,
   input  logic             tick_ser,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic             sel_q,
   output bt_phase_t        phase
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic start_evt, stop_evt, tick;

   always_comb begin
      start_evt = sel_q ? ~lvl : fall;
      stop_evt  = sel_q ? rise : fall;
      tick      = sel_q ? tick_ser : tick_bus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         sel_q <= 1'b0;
         count <= '0;
         ovf   <= 1'b0;
      end else if (wr) begin
         sel_q <= clksel;
         count <= '0;
         ovf   <= 1'b0;
         phase <= (mode == BT_MODE_MEASURE) ? PH_ARMED : PH_IDLE;
      end else begin
         unique case (phase)
            PH_ARMED: if (start_evt) phase <= PH_RUN;
            PH_RUN: begin
               if (stop_evt) begin
                  phase <= PH_DONE;
               end else if (tick) begin
                  count <= count + 1'b1;
                  if (count == CNT_MAX) ovf <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/bittime_meter.sv
module bittime_meter
   import bt_pkg::*;
#(
   parameter int CNT_W    = 9,
   parameter int LO_W     = 8,
   parameter int BUS_DIV  = 4,
   parameter int SER_DIV  = 2,
   parameter int SYNC_STG = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rxd_in,
   input  logic                  ser_clk_en,
   input  logic                  ctl_wr,
   input  logic [1:0]            ctl_mode,
   input  logic                  ctl_clksel,
   output logic [CNT_W-LO_W-1:0] cnt_hi,
   output logic [LO_W-1:0]       cnt_lo,
   output logic                  running,
   output logic                  finished,
   output logic                  overflow
);
   generate
      if (CNT_W <= LO_W || LO_W < 1) begin : g_bad_width
         $error("bittime_meter: CNT_W must exceed LO_W");
      end
      if (BUS_DIV < 1 || SER_DIV < 1) begin : g_bad_div
         $error("bittime_meter: dividers must be at least 1");
      end
      if (SYNC_STG < 2) begin : g_bad_sync
         $error("bittime_meter: synchroniser needs two stages");
      end
   endgenerate

   logic             lvl, rise, fall;
   logic             tick_bus, tick_ser, div_clr, sel_q;
   logic [CNT_W-1:0] count;
   bt_phase_t        phase;

   assign div_clr = (phase != PH_RUN) | ctl_wr;

   bt_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(rxd_in),
      .lvl(lvl), .rise(rise), .fall(fall)
   );

   bt_rate #(.DIV(BUS_DIV)) u_bus_rate (
      .clk(clk), .rst_n(rst_n), .clr(div_clr | sel_q),
      .src_en(1'b1), .tick(tick_bus)
   );

   bt_rate #(.DIV(SER_DIV)) u_ser_rate (
      .clk(clk), .rst_n(rst_n), .clr(div_clr | ~sel_q),
      .src_en(ser_clk_en), .tick(tick_ser)
   );

   bt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .mode(ctl_mode),
      .clksel(ctl_clksel), .lvl(lvl), .rise(rise), .fall(fall),
      .tick_bus(tick_bus), .tick_ser(tick_ser), .count(count),
      .ovf(overflow), .sel_q(sel_q), .phase(phase)
   );

   assign cnt_hi   = count[CNT_W-1:LO_W];
   assign cnt_lo   = count[LO_W-1:0];
   assign running  = (phase == PH_RUN);
   assign finished = (phase == PH_DONE);
endmodule

// File: rtl/bt_chk.sv
module bt_chk #(
   parameter int CNT_W = 9,
   parameter int LO_W  = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ctl_wr,
   input logic [1:0]            ctl_mode,
   input logic [CNT_W-LO_W-1:0] cnt_hi,
   input logic [LO_W-1:0]       cnt_lo,
   input logic                  running,
   input logic                  finished,
   input logic                  overflow
);
   logic [CNT_W-1:0] value;
   assign value = {cnt_hi, cnt_lo};

   assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(running && finished));

   assert_wr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (value == '0) && !overflow && !finished);

   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !ctl_wr |=> overflow);

   assert_hold_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      finished && !ctl_wr |=> finished && $stable(value));

   assert_still_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !ctl_wr |=> $stable(value));

   assert_idle_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr && (ctl_mode != 2'b01) |=> !running && !finished);
endmodule

bind bittime_meter bt_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) u_chk (.*);

// File: tb/tb_bittime_meter.sv
module tb_bittime_meter;
   localparam int CNT_W = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd_in = 1'b1;
   logic       ser_clk_en = 1'b1;
   logic       ctl_wr = 1'b0;
   logic [1:0] ctl_mode = 2'b00;
   logic       ctl_clksel = 1'b0;
   logic [0:0] cnt_hi;
   logic [7:0] cnt_lo;
   logic       running, finished, overflow;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit fin_d = 1'b0;

   typedef struct {
      int    cnt;
      bit    ovf;
      string req;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   bittime_meter dut (
      .clk(clk), .rst_n(rst_n), .rxd_in(rxd_in), .ser_clk_en(ser_clk_en),
      .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_clksel(ctl_clksel),
      .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .running(running),
      .finished(finished), .overflow(overflow)
   );

   function automatic int value();
      return int'({cnt_hi, cnt_lo});
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_ctl(logic [1:0] m, logic s);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_mode = m; ctl_clksel = s;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   // scoreboard driver: edge-to-edge measurement, falls P cycles apart
   task automatic run_fall(int p, string req);
      exp_t e;
      wr_ctl(2'b01, 1'b0);
      repeat (3) @(negedge clk);
      e.cnt = ((p - 1) / 4) % (1 << CNT_W);
      e.ovf = ((p - 1) / 4) >= (1 << CNT_W);
      e.req = req;
      sb.push_back(e);
      rxd_in = 1'b0;
      repeat (2) @(negedge clk);
      rxd_in = 1'b1;
      repeat (p - 2) @(negedge clk);
      rxd_in = 1'b0;
      repeat (6) @(negedge clk);
      rxd_in = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // scoreboard driver: low duration of L cycles
   task automatic run_low(int l, int ser_ticks_per_cnt, string req);
      exp_t e;
      wr_ctl(2'b01, 1'b1);
      repeat (3) @(negedge clk);
      e.cnt = (ser_ticks_per_cnt == 0) ? 0 : ((l - 1) / 2) % (1 << CNT_W);
      e.ovf = (ser_ticks_per_cnt != 0) && (((l - 1) / 2) >= (1 << CNT_W));
      e.req = req;
      sb.push_back(e);
      rxd_in = 1'b0;
      repeat (l) @(negedge clk);
      rxd_in = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (finished && !fin_d) begin
            if (sb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R3 unexpected finish actual=1 expected=0");
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk({e.req, " count"}, value(), e.cnt);
               chk({e.req, " overflow"}, int'(overflow), int'(e.ovf));
            end
         end
         fin_d <= finished;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", value(), 0);
      chk("R1 running", int'(running), 0);
      chk("R1 finished", int'(finished), 0);
      chk("R1 overflow", int'(overflow), 0);

      // R2 edge-to-edge at bus/4, several spacings
      run_fall(9, "R2 p9");
      run_fall(40, "R2 p40");
      run_fall(103, "R2 p103");

      // R9 hold after finish: extra falls do not change the result
      rxd_in = 1'b0; repeat (3) @(negedge clk);
      rxd_in = 1'b1; repeat (3) @(negedge clk);
      rxd_in = 1'b0; repeat (3) @(negedge clk);
      rxd_in = 1'b1; repeat (5) @(negedge clk);
      chk("R9 held count", value(), 25);
      chk("R9 finished held", int'(finished), 1);

      // R3 running visible mid-measurement
      wr_ctl(2'b01, 1'b1);
      repeat (3) @(negedge clk);
      begin
         exp_t e;
         e.cnt = 7; e.ovf = 1'b0; e.req = "R4 l15";
         sb.push_back(e);
      end
      rxd_in = 1'b0;
      repeat (8) @(negedge clk);
      chk("R3 running during low", int'(running), 1);
      chk("R3 not finished while running", int'(finished), 0);
      repeat (7) @(negedge clk);
      rxd_in = 1'b1;
      repeat (6) @(negedge clk);
      chk("R3 finished after stop", int'(finished), 1);
      chk("R3 running after stop", int'(running), 0);

      // R4 low duration at serial/2
      run_low(50, 1, "R4 l50");

      // R7 write clears status and count
      wr_ctl(2'b01, 1'b0);
      @(negedge clk);
      chk("R7 count cleared", value(), 0);
      chk("R7 finished cleared", int'(finished), 0);

      // R5 immediate start when line already low
      rxd_in = 1'b0;
      repeat (4) @(negedge clk);
      begin
         exp_t e;
         e.cnt = 10; e.ovf = 1'b0; e.req = "R5 immediate";
         sb.push_back(e);
      end
      wr_ctl(2'b01, 1'b1);
      repeat (3) @(negedge clk);
      chk("R5 running without edge", int'(running), 1);
      repeat (17) @(negedge clk);
      rxd_in = 1'b1;
      repeat (6) @(negedge clk);

      // R6 overflow on wrap, sticky, cleared by write
      run_low(1031, 1, "R6 wrap");
      repeat (10) @(negedge clk);
      chk("R6 overflow sticky", int'(overflow), 1);
      wr_ctl(2'b10, 1'b0);
      @(negedge clk);
      chk("R7 overflow cleared", int'(overflow), 0);

      // R8 idle modes ignore the line
      rxd_in = 1'b0; repeat (5) @(negedge clk);
      rxd_in = 1'b1; repeat (5) @(negedge clk);
      rxd_in = 1'b0; repeat (5) @(negedge clk);
      chk("R8 mode10 not running", int'(running), 0);
      chk("R8 mode10 count", value(), 0);
      rxd_in = 1'b1;
      wr_ctl(2'b00, 1'b0);
      rxd_in = 1'b0; repeat (5) @(negedge clk);
      rxd_in = 1'b1; repeat (5) @(negedge clk);
      rxd_in = 1'b0; repeat (5) @(negedge clk);
      chk("R8 mode00 not running", int'(running), 0);
      chk("R8 mode00 finished", int'(finished), 0);
      rxd_in = 1'b1;
      wr_ctl(2'b11, 1'b1);
      rxd_in = 1'b0; repeat (8) @(negedge clk);
      chk("R8 mode11 not running", int'(running), 0);
      rxd_in = 1'b1; repeat (4) @(negedge clk);

      // R10 no serial strobes means no counting
      ser_clk_en = 1'b0;
      run_low(30, 0, "R10 no strobe");
      ser_clk_en = 1'b1;

      repeat (5) @(negedge clk);
      chk("R3 scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule